// File: doc/BRIEF.md
# Challenge-Response Authentication Command Controller

This block is the command layer of a small authentication peripheral. It receives function-command bytes, with a valid strobe, from a serial link that has already selected the device. It holds a 64-bit secret, a 64-bit challenge, a lock bit for the secret and a persistent bit that selects the link speed. An external hash engine and an external non-volatile store are reached through request/done handshakes.

Message-authentication commands ask the hash engine for a digest. The digest is computed either with the device identifier or with all ones in its place, and it is then streamed out one byte per output request. Secret-derivation commands also run the hash, but they keep the low 64 digest bits as the new secret and then commit it to storage. The clear, lock and speed commands change their register and then start one storage write. Once the lock bit is set, every attempt to change the secret leaves it untouched and raises an error flag.

Top module: `auth_cmd_ctrl`

## Requirements
- R1: After reset the secret is all zeros and the lock bit is clear. The speed bit is 0, which means standard speed. No challenge is loaded, and busy, hash_req, nv_wr_req, tx_valid and lock_err are all low.
- R2: Opcode 0x0C is followed by eight data bytes, which form the challenge with the first byte in bits 7:0 and the last byte in bits 63:56. chal_loaded rises once the eighth byte has been taken.
- R3: While no challenge is loaded, the opcodes 0x35, 0x36, 0x33 and 0x30 are dropped and no hash request is made. hash_req is never high without a loaded challenge.
- R4: Opcode 0x35 requests a hash with hash_sel_next=0 and hash_ones_id=0. Opcode 0x36 does the same with hash_ones_id=1. The 20 digest bytes are then presented least significant byte first, and each tx_req consumes one of them. After the 20th byte tx_valid falls.
- R5: Opcode 0x33 requests a hash with hash_sel_next=1 and hash_ones_id=0. Opcode 0x30 does the same with hash_ones_id=1. Digest bits 63:0 become the secret, and exactly one storage write follows.
- R6: Opcode 0x5A sets the secret to all zeros and then performs one storage write.
- R7: Opcode 0x6A sets the lock bit and performs one storage write. While the lock bit is set, 0x5A, 0x33 and 0x30 leave the secret unchanged, start no hash and no write, and set lock_err. lock_err clears on the next opcode accepted in idle.
- R8: Opcode 0x8B sets the speed bit to 1 (overdrive) and opcode 0x8D sets it to 0 (standard). Each of them performs one storage write.
- R9: busy is high while a hash or a storage write is outstanding, and bytes arriving during that time are ignored. hash_req and nv_wr_req are never high together.
- R10: Any opcode outside the nine listed sends the controller into a halt state. In that state every byte is ignored until bus_reset is pulsed.
- R11: hash_req stays high until hash_done arrives, and nv_wr_req stays high until nv_wr_done arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_reset | input | 1 | Link reset pulse; leaves halt, challenge loading or digest output |
| rx_valid | input | 1 | rx_byte holds a new byte |
| rx_byte | input | 8 | Byte received from the link |
| tx_req | input | 1 | Consumes the presented digest byte |
| tx_valid | output | 1 | A digest byte is presented |
| tx_byte | output | 8 | Presented digest byte |
| hash_req | output | 1 | Hash request, held until done |
| hash_sel_next | output | 1 | 1 = secret-derivation message, 0 = authentication message |
| hash_ones_id | output | 1 | Hash uses all ones in place of the device ID |
| hash_done | input | 1 | Hash finished; digest valid |
| hash_digest | input | 160 | Digest from the hash engine |
| secret_o | output | 64 | Current secret, fed to the hash engine |
| challenge_o | output | 64 | Current challenge, fed to the hash engine |
| nv_wr_req | output | 1 | Storage write request, held until done |
| nv_wr_done | input | 1 | Storage write completed |
| busy | output | 1 | Hash or storage write outstanding |
| lock_err | output | 1 | Last secret-changing command was refused by the lock |
| secret_locked | output | 1 | Lock bit |
| speed_od | output | 1 | Speed bit, 1 = overdrive |
| chal_loaded | output | 1 | A complete challenge has been loaded |

## Verification
The bench sends an authentication command before any challenge exists. A controller that skipped the check would start a hash on an undefined challenge. It sends a clear while a derivation hash is still running. If busy were not honoured, the derived secret would be overwritten by zeros. Once the secret is locked, the bench tries derive and clear and expects the secret, the hash count and the write count all to stay as they were. It also checks that the digest appears in least-significant-first order, and that an unknown opcode blocks a later speed command until a link reset.

// File: rtl/auth_pkg.sv
package auth_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] OP_CHAL      = 8'h0C;
  localparam logic [7:0] OP_MAC_ID    = 8'h35;
  localparam logic [7:0] OP_MAC_ONES  = 8'h36;
  localparam logic [7:0] OP_NEXT_ID   = 8'h33;
  localparam logic [7:0] OP_NEXT_ONES = 8'h30;
  localparam logic [7:0] OP_CLEAR     = 8'h5A;
  localparam logic [7:0] OP_LOCK      = 8'h6A;
  localparam logic [7:0] OP_SPD_STD   = 8'h8D;
  localparam logic [7:0] OP_SPD_OD    = 8'h8B;

  typedef enum logic [2:0] {
    K_CHAL, K_MAC, K_NEXT, K_CLEAR, K_LOCK, K_SPEED, K_BAD
  } cmd_kind_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHAL, ST_HASH, ST_MAC, ST_NV, ST_HALT
  } state_t;
endpackage

// File: rtl/auth_cmd_decode.sv
module auth_cmd_decode
  import auth_pkg::*;
(
  input  logic [7:0] op,
  output cmd_kind_t  kind,
  output logic       use_ones,
  output logic       speed_val
);
  always_comb begin
    kind      = K_BAD;
    use_ones  = 1'b0;
    speed_val = 1'b0;
    case (op)
      OP_CHAL:      kind = K_CHAL;
      OP_MAC_ID:    kind = K_MAC;
      OP_MAC_ONES:  begin kind = K_MAC;  use_ones = 1'b1; end
      OP_NEXT_ID:   kind = K_NEXT;
      OP_NEXT_ONES: begin kind = K_NEXT; use_ones = 1'b1; end
      OP_CLEAR:     kind = K_CLEAR;
      OP_LOCK:      kind = K_LOCK;
      OP_SPD_STD:   kind = K_SPEED;
      OP_SPD_OD:    begin kind = K_SPEED; speed_val = 1'b1; end
      default:      kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/auth_chal_capture.sv
module auth_chal_capture #(
  parameter int KEY_W  = 64,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              byte_en,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              last,
  output logic [KEY_W-1:0]  chal,
  output logic              chal_ok
);
  localparam int NBYTES = KEY_W / BYTE_W;
  localparam int CNT_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NBYTES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [KEY_W-1:0] stage_q, stage_d;
  logic [KEY_W-1:0] chal_q, chal_d;
  logic             ok_q, ok_d;

  assign last = (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d   = cnt_q;
    stage_d = stage_q;
    chal_d  = chal_q;
    ok_d    = ok_q;
    if (start) begin
      cnt_d = '0;
    end else if (byte_en) begin
      stage_d = {byte_in, stage_q[KEY_W-1:BYTE_W]};
      cnt_d   = cnt_q + 1'b1;
      if (last) begin
        chal_d = stage_d;
        ok_d   = 1'b1;
        cnt_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      stage_q <= '0;
      chal_q  <= '0;
      ok_q    <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      stage_q <= stage_d;
      chal_q  <= chal_d;
      ok_q    <= ok_d;
    end
  end

  assign chal    = chal_q;
  assign chal_ok = ok_q;
endmodule

// File: rtl/auth_mac_stream.sv
module auth_mac_stream #(
  parameter int DIG_W  = 160,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DIG_W-1:0]  digest_in,
  input  logic              adv,
  output logic [BYTE_W-1:0] byte_out,
  output logic              last
);
  localparam int NBYTES = DIG_W / BYTE_W;
  localparam int CNT_W  = $clog2(NBYTES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NBYTES - 1);

  logic [DIG_W-1:0] dig_q, dig_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    dig_d = dig_q;
    cnt_d = cnt_q;
    if (load) begin
      dig_d = digest_in;
      cnt_d = '0;
    end else if (adv) begin
      dig_d = dig_q >> BYTE_W;
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dig_q <= '0;
      cnt_q <= '0;
    end else begin
      dig_q <= dig_d;
      cnt_q <= cnt_d;
    end
  end

  assign byte_out = dig_q[BYTE_W-1:0];
  assign last     = (cnt_q == CNT_LAST);
endmodule

// File: rtl/auth_cmd_ctrl.sv
module auth_cmd_ctrl
  import auth_pkg::*;
#(
  parameter int KEY_W = 64,
  parameter int DIG_W = 160
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              tx_req,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              hash_req,
  output logic              hash_sel_next,
  output logic              hash_ones_id,
  input  logic              hash_done,
  input  logic [DIG_W-1:0]  hash_digest,
  output logic [KEY_W-1:0]  secret_o,
  output logic [KEY_W-1:0]  challenge_o,
  output logic              nv_wr_req,
  input  logic              nv_wr_done,
  output logic              busy,
  output logic              lock_err,
  output logic              secret_locked,
  output logic              speed_od,
  output logic              chal_loaded
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cmd_kind_t kind;
  logic      use_ones, speed_val;

  auth_cmd_decode u_dec (
    .op(rx_byte), .kind(kind), .use_ones(use_ones), .speed_val(speed_val)
  );

  state_t            state_q, state_d;
  logic [KEY_W-1:0]  secret_q, secret_d;
  logic              lock_q, lock_d, speed_q, speed_d, err_q, err_d;
  logic              sel_q, sel_d, ones_q, ones_d;
  logic              chal_start, chal_byte_en, chal_last, chal_ok;
  logic              mac_load, mac_adv, mac_last;

  auth_chal_capture #(.KEY_W(KEY_W), .BYTE_W(BYTE_W)) u_chal (
    .clk(clk), .rst_n(rst_int_n), .start(chal_start), .byte_en(chal_byte_en),
    .byte_in(rx_byte), .last(chal_last), .chal(challenge_o), .chal_ok(chal_ok)
  );

  auth_mac_stream #(.DIG_W(DIG_W), .BYTE_W(BYTE_W)) u_mac (
    .clk(clk), .rst_n(rst_int_n), .load(mac_load), .digest_in(hash_digest),
    .adv(mac_adv), .byte_out(tx_byte), .last(mac_last)
  );

  // next-state
  always_comb begin
    state_d      = state_q;
    secret_d     = secret_q;
    lock_d       = lock_q;
    speed_d      = speed_q;
    err_d        = err_q;
    sel_d        = sel_q;
    ones_d       = ones_q;
    chal_start   = 1'b0;
    chal_byte_en = 1'b0;
    mac_load     = 1'b0;
    mac_adv      = 1'b0;
    case (state_q)
      ST_IDLE: if (rx_valid) begin
        err_d = 1'b0;
        case (kind)
          K_CHAL: begin
            chal_start = 1'b1;
            state_d    = ST_CHAL;
          end
          K_MAC, K_NEXT: if (chal_ok) begin
            sel_d  = (kind == K_NEXT);
            ones_d = use_ones;
            if (kind == K_NEXT && lock_q) err_d   = 1'b1;
            else                          state_d = ST_HASH;
          end
          K_CLEAR: begin
            if (lock_q) err_d = 1'b1;
            else begin
              secret_d = '0;
              state_d  = ST_NV;
            end
          end
          K_LOCK: begin
            lock_d  = 1'b1;
            state_d = ST_NV;
          end
          K_SPEED: begin
            speed_d = speed_val;
            state_d = ST_NV;
          end
          default: state_d = ST_HALT;
        endcase
      end
      ST_CHAL: begin
        if (bus_reset) state_d = ST_IDLE;
        else if (rx_valid) begin
          chal_byte_en = 1'b1;
          if (chal_last) state_d = ST_IDLE;
        end
      end
      ST_HASH: if (hash_done) begin
        if (sel_q) begin
          secret_d = hash_digest[KEY_W-1:0];
          state_d  = ST_NV;
        end else begin
          mac_load = 1'b1;
          state_d  = ST_MAC;
        end
      end
      ST_MAC: begin
        if (bus_reset) state_d = ST_IDLE;
        else if (tx_req) begin
          mac_adv = 1'b1;
          if (mac_last) state_d = ST_IDLE;
        end
      end
      ST_NV:   if (nv_wr_done) state_d = ST_IDLE;
      ST_HALT: if (bus_reset)  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q  <= ST_IDLE;
      secret_q <= '0;
      lock_q   <= 1'b0;
      speed_q  <= 1'b0;
      err_q    <= 1'b0;
      sel_q    <= 1'b0;
      ones_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      secret_q <= secret_d;
      lock_q   <= lock_d;
      speed_q  <= speed_d;
      err_q    <= err_d;
      sel_q    <= sel_d;
      ones_q   <= ones_d;
    end
  end

  assign hash_req      = (state_q == ST_HASH);
  assign nv_wr_req     = (state_q == ST_NV);
  assign busy          = hash_req | nv_wr_req;
  assign tx_valid      = (state_q == ST_MAC);
  assign hash_sel_next = sel_q;
  assign hash_ones_id  = ones_q;
  assign secret_o      = secret_q;
  assign secret_locked = lock_q;
  assign speed_od      = speed_q;
  assign lock_err      = err_q;
  assign chal_loaded   = chal_ok;

  AST_HASH_NEEDS_CHAL: assert property (@(posedge clk) disable iff (!rst_int_n)
    hash_req |-> chal_loaded); // R3
  AST_LOCKED_SECRET_FROZEN: assert property (@(posedge clk) disable iff (!rst_int_n)
    secret_locked |=> $stable(secret_o)); // R7
  AST_REFUSAL_NO_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(lock_err) |-> (!hash_req && !nv_wr_req)); // R7
  AST_ONE_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(hash_req && nv_wr_req)); // R9
  AST_HASH_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (hash_req && !hash_done) |=> hash_req); // R11
  AST_NV_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (nv_wr_req && !nv_wr_done) |=> nv_wr_req); // R11
endmodule

// File: tb/sim_auth_cmd_ctrl.sv
module sim_auth_cmd_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_reset = 1'b0, rx_valid = 1'b0, tx_req = 1'b0;
  logic [7:0]   rx_byte = '0;
  logic         tx_valid, hash_req, hash_sel_next, hash_ones_id, nv_wr_req;
  logic [7:0]   tx_byte;
  logic         hash_done = 1'b0, nv_wr_done = 1'b0;
  logic [159:0] hash_digest = '0;
  logic [63:0]  secret_o, challenge_o;
  logic         busy, lock_err, secret_locked, speed_od, chal_loaded;

  always #2 clk = ~clk; // 250 MHz

  auth_cmd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_req(tx_req), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .hash_req(hash_req), .hash_sel_next(hash_sel_next), .hash_ones_id(hash_ones_id),
    .hash_done(hash_done), .hash_digest(hash_digest), .secret_o(secret_o),
    .challenge_o(challenge_o), .nv_wr_req(nv_wr_req), .nv_wr_done(nv_wr_done),
    .busy(busy), .lock_err(lock_err), .secret_locked(secret_locked),
    .speed_od(speed_od), .chal_loaded(chal_loaded)
  );

  localparam logic [63:0] DEV_ID = 64'h1122_3344_5566_7788;

  int checks = 0, fails = 0, hash_cnt = 0, nv_cnt = 0;
  logic [7:0]  exp_q[$];
  logic [63:0] m_secret = '0, m_chal = '0;
  bit          finished = 0;

  function automatic logic [159:0] hash_model(logic [63:0] s, logic [63:0] c, logic ones, logic sel);
    logic [63:0] idv;
    idv = ones ? {64{1'b1}} : DEV_ID;
    return {s[63:32] ^ 32'hC3C3_0F0F, c + idv + {63'b0, sel}, s ^ {c[31:0], c[63:32]} ^ idv};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && (busy || tx_valid); i++) @(negedge clk);
  endtask

  // hash engine model
  initial forever begin
    @(negedge clk);
    if (hash_req) begin
      repeat (3) @(negedge clk);
      hash_digest = hash_model(secret_o, challenge_o, hash_ones_id, hash_sel_next);
      hash_done = 1'b1; hash_cnt++;
      @(negedge clk); hash_done = 1'b0;
    end
  end

  // storage model
  initial forever begin
    @(negedge clk);
    if (nv_wr_req) begin
      repeat (2) @(negedge clk);
      nv_wr_done = 1'b1; nv_cnt++;
      @(negedge clk); nv_wr_done = 1'b0;
    end
  end

  // scoreboard monitor for streamed digest bytes
  initial forever begin
    @(posedge clk);
    if (tx_valid && tx_req) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected byte", {56'b0, tx_byte}, 64'h0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(tx_byte == e, "R4 digest byte", {56'b0, tx_byte}, {56'b0, e});
      end
    end
  end

  task automatic push_mac(input logic ones);
    logic [159:0] d;
    d = hash_model(m_secret, m_chal, ones, 1'b0);
    for (int i = 0; i < 20; i++) exp_q.push_back(d[i*8 +: 8]);
  endtask

  task automatic run_mac(input logic [7:0] op, input logic ones, input string tag);
    push_mac(ones);
    send_byte(op);
    chk(hash_req && !hash_sel_next && hash_ones_id == ones, tag, {62'b0, hash_sel_next, hash_ones_id}, {63'b0, ones});
    for (int i = 0; i < 50 && !tx_valid; i++) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); tx_req = 1'b1;
      @(negedge clk); tx_req = 1'b0;
    end
    chk(!tx_valid && exp_q.size() == 0, "R4 stream ends after 20 bytes", {63'b0, tx_valid}, 64'h0);
  endtask

  task automatic run_next(input logic [7:0] op, input logic ones, input string tag);
    int n0;
    logic [159:0] d;
    n0 = nv_cnt;
    d = hash_model(m_secret, m_chal, ones, 1'b1);
    send_byte(op);
    chk(hash_req && hash_sel_next && hash_ones_id == ones, tag, {62'b0, hash_sel_next, hash_ones_id}, {62'b0, 1'b1, ones});
    wait_idle();
    m_secret = d[63:0];
    chk(secret_o == m_secret, "R5 derived secret", secret_o, m_secret);
    chk(nv_cnt == n0 + 1, "R5 one write", 64'(nv_cnt), 64'(n0 + 1));
  endtask

  initial begin
    int h0, n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(secret_o == 0 && !secret_locked && !speed_od && !chal_loaded, "R1 reset regs",
        {secret_o[59:0], secret_locked, speed_od, chal_loaded, 1'b0}, 64'h0);
    chk(!busy && !hash_req && !nv_wr_req && !tx_valid && !lock_err, "R1 reset outputs",
        {59'b0, busy, hash_req, nv_wr_req, tx_valid, lock_err}, 64'h0);
    // R3
    send_byte(8'h35);
    send_byte(8'h33);
    repeat (3) @(negedge clk);
    chk(hash_cnt == 0 && !busy, "R3 no hash without challenge", 64'(hash_cnt), 64'h0);
    // R2
    m_chal = 64'hF0E1_D2C3_B4A5_9687;
    send_byte(8'h0C);
    for (int i = 0; i < 8; i++) send_byte(m_chal[i*8 +: 8]);
    chk(challenge_o == m_chal && chal_loaded, "R2 challenge", challenge_o, m_chal);
    // R4
    run_mac(8'h35, 1'b0, "R4 request with ID");
    run_mac(8'h36, 1'b1, "R4 request with ones");
    // R5
    run_next(8'h33, 1'b0, "R5 derive with ID");
    run_next(8'h30, 1'b1, "R5 derive with ones");
    // R8
    n0 = nv_cnt;
    send_byte(8'h8B); wait_idle();
    chk(speed_od && nv_cnt == n0 + 1, "R8 overdrive", {63'b0, speed_od}, 64'h1);
    send_byte(8'h8D); wait_idle();
    chk(!speed_od && nv_cnt == n0 + 2, "R8 standard", {63'b0, speed_od}, 64'h0);
    // R9: clear sent while hash busy is dropped
    begin
      logic [159:0] d;
      d = hash_model(m_secret, m_chal, 1'b0, 1'b1);
      n0 = nv_cnt;
      send_byte(8'h33);
      chk(busy, "R9 busy during hash", {63'b0, busy}, 64'h1);
      send_byte(8'h5A);
      wait_idle();
      m_secret = d[63:0];
      chk(secret_o == m_secret && nv_cnt == n0 + 1, "R9 byte during busy ignored", secret_o, m_secret);
    end
    // R6
    n0 = nv_cnt;
    send_byte(8'h5A);
    chk(busy, "R6 write started", {63'b0, busy}, 64'h1);
    wait_idle(); m_secret = '0;
    chk(secret_o == 0 && nv_cnt == n0 + 1, "R6 cleared", secret_o, 64'h0);
    run_next(8'h33, 1'b0, "R5 derive before lock");
    // R7
    n0 = nv_cnt;
    send_byte(8'h6A); wait_idle();
    chk(secret_locked && nv_cnt == n0 + 1, "R7 lock set", {63'b0, secret_locked}, 64'h1);
    h0 = hash_cnt; n0 = nv_cnt;
    send_byte(8'h33);
    repeat (4) @(negedge clk);
    chk(lock_err && secret_o == m_secret, "R7 derive refused", secret_o, m_secret);
    send_byte(8'h5A);
    repeat (4) @(negedge clk);
    chk(lock_err && secret_o == m_secret, "R7 clear refused", secret_o, m_secret);
    chk(hash_cnt == h0 && nv_cnt == n0, "R7 no hash or write", 64'(nv_cnt), 64'(n0));
    send_byte(8'h8D); wait_idle();
    chk(!lock_err && nv_cnt == n0 + 1, "R7 error cleared by next opcode", {63'b0, lock_err}, 64'h0);
    // R10
    n0 = nv_cnt;
    send_byte(8'h77);
    send_byte(8'h8B);
    repeat (6) @(negedge clk);
    chk(!speed_od && nv_cnt == n0, "R10 halted ignores bytes", {63'b0, speed_od}, 64'h0);
    @(negedge clk); bus_reset = 1'b1;
    @(negedge clk); bus_reset = 1'b0;
    send_byte(8'h8B); wait_idle();
    chk(speed_od && nv_cnt == n0 + 1, "R10 resumes after bus reset", {63'b0, speed_od}, 64'h1);
    finished = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !finished; i++) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule